// File: doc/BRIEF.md
# Selectable Output Test Pattern Generator

This block sits after a data converter and produces one 12-bit word on every sample clock. In normal operation the word is the live sample passed through a single register stage. When a non-zero pattern code is selected, a synthetic test word takes the place of the live sample. Test words include fixed levels, alternating and walking bit patterns, two pseudo-random streams and a pair of words supplied by the user. A receiver can check such a stream against a known answer to confirm that its capture path and bit alignment are correct.

Each pseudo-random generator has its own hold input. While a hold is asserted, that generator is parked at its all-ones seed. A two-bit sequencing field selects how the user words play out: a constant word, two words alternating, one word emitted once, or a pair of words emitted once. In the once cases the output falls back to live data after the words have been sent. A sample index restarts whenever the pattern code or the sequencing field changes. Every sequence therefore begins from its first word.

Top module: `tpg_top`

## Requirements
- R1: While `rst` is high, `word_out` reads 0x000 and `word_valid` reads 0. From the first clock edge after `rst` falls, `word_valid` is 1 on every cycle.
- R2: Pattern code 0000, and the unused codes 1101, 1110 and 1111, put the live word sampled at a clock edge onto `word_out` after that edge, with one cycle of latency.
- R3: Code 0001 gives 0x800, code 0010 gives 0xFFF and code 0011 gives 0x000.
- R4: Code 0100 gives 0xAAA on the first sample after it is selected, then alternates 0x555 and 0xAAA.
- R5: Code 0111 alternates 0xFFF and 0x000, starting with 0xFFF. Code 1001 gives 0xAAA on every sample.
- R6: Code 1010 gives 0x03F. Code 1011 gives 0x001 on the first sample, moves the single 1 one place toward the MSB on each sample, and returns to 0x001 after 0x800.
- R7: Code 1100 (mixed bit frequency) sets output bit k equal to bit (k mod 4) of the sample index, where the index is 0 on the first sample after selection.
- R8: The short generator implements x^9+x^5+1 (feedback = state bit 8 XOR state bit 4, shifted in at bit 0). It starts at all ones and takes 12 steps per sample, and code 0110 outputs the 12 feedback bits of those steps with the oldest bit in the MSB. The generator advances on every sample whatever code is selected.
- R9: The long generator behaves the same way with x^23+x^18+1 (feedback = bit 22 XOR bit 17) and appears under code 0101.
- R10: While a generator's hold input is high, that generator's state stays at all ones, and its word for that sample is the 12 feedback bits computed from the all-ones seed. Each hold affects only its own generator.
- R11: With code 1000, sequencing 00 gives `user_word_a` on every sample. Sequencing 01 alternates `user_word_a` and `user_word_b`, starting with `user_word_a`.
- R12: With code 1000, sequencing 10 gives `user_word_a` once and then live data. Sequencing 11 gives `user_word_a`, then `user_word_b`, then live data.
- R13: Any change of the pattern code or the sequencing field resets the sample index, the walking position and the once progress, so the new setting begins at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| live_word | input | 12 | Live converter sample |
| pat_sel | input | 4 | Pattern code |
| seq_sel | input | 2 | User word sequencing: 00 constant, 01 alternate, 10 once, 11 pair once |
| pn_long_hold | input | 1 | Hold the long generator at its seed |
| pn_short_hold | input | 1 | Hold the short generator at its seed |
| user_word_a | input | 12 | First user test word |
| user_word_b | input | 12 | Second user test word |
| word_out | output | 12 | Registered output word |
| word_valid | output | 1 | High on every sample after reset |

## Verification
Two functions can fall in the same cycle. The first is a sequencing-field change that lands on the cycle where a pair-once sequence would emit its second word. The second is a generator hold that is released on the very sample where the pseudo-random pattern is being read. The bench provokes the first by changing the sequencing field from 11 to 10 right after the first user word, and expects the restart to win, so `user_word_a` is sent again rather than `user_word_b`. It provokes the second by toggling each hold while the other generator keeps running. Each output is judged against a bench model of both polynomials, so both the seed word and the continued stream must match.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W = 12;
    localparam int WALK_W = $clog2(WORD_W);
    localparam int IDX_W  = 4;

    localparam int SHORT_LEN = 9;
    localparam int SHORT_TAP = 5;
    localparam int LONG_LEN  = 23;
    localparam int LONG_TAP  = 18;

    typedef enum logic [3:0] {
        PAT_LIVE    = 4'd0,
        PAT_MID     = 4'd1,
        PAT_POS     = 4'd2,
        PAT_NEG     = 4'd3,
        PAT_CHECK   = 4'd4,
        PAT_PN_LONG = 4'd5,
        PAT_PN_SHRT = 4'd6,
        PAT_WTOG    = 4'd7,
        PAT_USER    = 4'd8,
        PAT_BTOG    = 4'd9,
        PAT_SYNC    = 4'd10,
        PAT_WALK    = 4'd11,
        PAT_MIXED   = 4'd12
    } pat_e;

    typedef enum logic [1:0] {
        SEQ_REPEAT   = 2'd0,
        SEQ_ALT      = 2'd1,
        SEQ_ONCE     = 2'd2,
        SEQ_ALT_ONCE = 2'd3
    } seq_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WALK_W-1:0] walk;
        logic [1:0]        once;
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] live;
        logic [WORD_W-1:0] ua;
        logic [WORD_W-1:0] ub;
        logic [WORD_W-1:0] pn_long;
        logic [WORD_W-1:0] pn_short;
    } src_words_t;

    // Word whose bits alternate, MSB first taking the value hi_first.
    function automatic logic [WORD_W-1:0] alt_bits(input logic hi_first);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < WORD_W; k++) begin
            w[k] = ((k % 2) == 1) ? hi_first : ~hi_first;
        end
        return w;
    endfunction

    // Lower half ones, upper half zeros.
    function automatic logic [WORD_W-1:0] low_half_ones();
        logic [WORD_W-1:0] w;
        for (int k = 0; k < WORD_W; k++) begin
            w[k] = (k < WORD_W / 2);
        end
        return w;
    endfunction

    // Bit k follows index bit (k mod IDX_W).
    function automatic logic [WORD_W-1:0] mixed_bits(input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < WORD_W; k++) begin
            w[k] = idx[k % IDX_W];
        end
        return w;
    endfunction

endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
    parameter int LEN = 9,
    parameter int TAP = 5,
    parameter int W   = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    output logic [W-1:0] pn_word
);
    logic [LEN-1:0] st_q;
    logic [LEN-1:0] st_walk;
    logic [LEN-1:0] st_next;
    logic           fb;

    // Advance W steps from the seed when held, else from the current state.
    always_comb begin
        st_walk = hold ? {LEN{1'b1}} : st_q;
        pn_word = '0;
        fb      = 1'b0;
        for (int k = 0; k < W; k++) begin
            fb             = st_walk[LEN-1] ^ st_walk[TAP-1];
            st_walk        = {st_walk[LEN-2:0], fb};
            pn_word[W-1-k] = fb;
        end
        st_next = hold ? {LEN{1'b1}} : st_walk;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= {LEN{1'b1}};
        else     st_q <= st_next;
    end

    assert_hold_seed_R10: assert property (@(posedge clk) disable iff (rst)
        hold |=> (st_q == {LEN{1'b1}}));

    assert_no_lockup_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q != '0) |=> (st_q != '0));

endmodule

// File: rtl/tpg_seq_ctrl.sv
module tpg_seq_ctrl
    import tpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  pat_sel,
    input  logic [1:0]  seq_sel,
    output seq_state_t  cur
);
    logic [5:0]        cfg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WALK_W-1:0] walk_q;
    logic [1:0]        once_q;
    logic              restart;

    assign restart = ({pat_sel, seq_sel} != cfg_q);

    always_comb begin
        cur.idx  = restart ? '0 : idx_q;
        cur.walk = restart ? '0 : walk_q;
        cur.once = restart ? '0 : once_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            idx_q  <= '0;
            walk_q <= '0;
            once_q <= '0;
        end else begin
            cfg_q  <= {pat_sel, seq_sel};
            idx_q  <= cur.idx + 1'b1;
            walk_q <= (cur.walk == WALK_W'(WORD_W - 1)) ? '0 : cur.walk + 1'b1;
            once_q <= (cur.once == 2'd2) ? 2'd2 : cur.once + 1'b1;
        end
    end

    assert_restart_index_R13: assert property (@(posedge clk) disable iff (rst)
        restart |=> (idx_q == IDX_W'(1) && walk_q == WALK_W'(1) && once_q == 2'd1));

    assert_once_saturates_R12: assert property (@(posedge clk) disable iff (rst)
        (once_q == 2'd2 && !restart) |=> (once_q == 2'd2));

    assert_walk_range_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (walk_q < WALK_W'(WORD_W)));

endmodule

// File: rtl/tpg_pattern_mux.sv
module tpg_pattern_mux
    import tpg_pkg::*;
(
    input  logic [3:0]        pat_sel,
    input  logic [1:0]        seq_sel,
    input  seq_state_t        st,
    input  src_words_t        src,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] user_w;

    always_comb begin
        case (seq_e'(seq_sel))
            SEQ_REPEAT:   user_w = src.ua;
            SEQ_ALT:      user_w = st.idx[0] ? src.ub : src.ua;
            SEQ_ONCE:     user_w = (st.once == 2'd0) ? src.ua : src.live;
            default:      user_w = (st.once == 2'd0) ? src.ua :
                                   (st.once == 2'd1) ? src.ub : src.live;
        endcase
    end

    always_comb begin
        case (pat_sel)
            PAT_LIVE:    word = src.live;
            PAT_MID:     word = {1'b1, {(WORD_W-1){1'b0}}};
            PAT_POS:     word = '1;
            PAT_NEG:     word = '0;
            PAT_CHECK:   word = alt_bits(~st.idx[0]);
            PAT_PN_LONG: word = src.pn_long;
            PAT_PN_SHRT: word = src.pn_short;
            PAT_WTOG:    word = st.idx[0] ? '0 : '1;
            PAT_USER:    word = user_w;
            PAT_BTOG:    word = alt_bits(1'b1);
            PAT_SYNC:    word = low_half_ones();
            PAT_WALK:    word = WORD_W'(1) << st.walk;
            PAT_MIXED:   word = mixed_bits(st.idx);
            default:     word = src.live;
        endcase
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] live_word,
    input  logic [3:0]        pat_sel,
    input  logic [1:0]        seq_sel,
    input  logic              pn_long_hold,
    input  logic              pn_short_hold,
    input  logic [WORD_W-1:0] user_word_a,
    input  logic [WORD_W-1:0] user_word_b,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    seq_state_t        st;
    src_words_t        src;
    logic [WORD_W-1:0] pn_long_w;
    logic [WORD_W-1:0] pn_short_w;
    logic [WORD_W-1:0] mux_w;

    tpg_seq_ctrl u_seq (
        .clk     (clk),
        .rst     (rst),
        .pat_sel (pat_sel),
        .seq_sel (seq_sel),
        .cur     (st)
    );

    tpg_prbs #(.LEN(LONG_LEN), .TAP(LONG_TAP), .W(WORD_W)) u_pn_long (
        .clk     (clk),
        .rst     (rst),
        .hold    (pn_long_hold),
        .pn_word (pn_long_w)
    );

    tpg_prbs #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .W(WORD_W)) u_pn_short (
        .clk     (clk),
        .rst     (rst),
        .hold    (pn_short_hold),
        .pn_word (pn_short_w)
    );

    always_comb begin
        src.live     = live_word;
        src.ua       = user_word_a;
        src.ub       = user_word_b;
        src.pn_long  = pn_long_w;
        src.pn_short = pn_short_w;
    end

    tpg_pattern_mux u_mux (
        .pat_sel (pat_sel),
        .seq_sel (seq_sel),
        .st      (st),
        .src     (src),
        .word    (mux_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_out   <= mux_w;
            word_valid <= 1'b1;
        end
    end

    assert_valid_high_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> word_valid);

    assert_live_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (pat_sel == 4'd0 || pat_sel >= 4'd13) |=> (word_out == $past(live_word)));

    assert_midscale_R3: assert property (@(posedge clk) disable iff (rst)
        (pat_sel == 4'd1) |=> (word_out == 12'h800));

    assert_sync_word_R6: assert property (@(posedge clk) disable iff (rst)
        (pat_sel == 4'd10) |=> (word_out == 12'h03F));

endmodule

// File: tb/tpg_top_tb.sv
`timescale 1ns/1ps
module tpg_top_tb;

    localparam time CLK_T = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] live_word;
    logic [3:0]  pat_sel;
    logic [1:0]  seq_sel;
    logic        pn_long_hold;
    logic        pn_short_hold;
    logic [11:0] user_word_a;
    logic [11:0] user_word_b;
    logic [11:0] word_out;
    logic        word_valid;

    always #(CLK_T/2) clk = ~clk;

    tpg_top u_dut (
        .clk           (clk),
        .rst           (rst),
        .live_word     (live_word),
        .pat_sel       (pat_sel),
        .seq_sel       (seq_sel),
        .pn_long_hold  (pn_long_hold),
        .pn_short_hold (pn_short_hold),
        .user_word_a   (user_word_a),
        .user_word_b   (user_word_b),
        .word_out      (word_out),
        .word_valid    (word_valid)
    );

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // Bench model state
    logic [5:0]  m_cfg;
    logic [3:0]  m_idx;
    logic [3:0]  m_walk;
    logic [1:0]  m_once;
    logic [22:0] m_pl;
    logic [8:0]  m_ps;

    // {mode, seq, hold_long, hold_short, cycles, fixed, expect}
    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  seq;
        logic        hl;
        logic        hs;
        logic [7:0]  cyc;
        logic        fixed;
        logic [11:0] expect_w;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  2'd0, 1'b0, 1'b0, 8'd4,  1'b0, 12'h000},
        '{4'd1,  2'd0, 1'b0, 1'b0, 8'd3,  1'b1, 12'h800},
        '{4'd2,  2'd0, 1'b0, 1'b0, 8'd3,  1'b1, 12'hFFF},
        '{4'd3,  2'd0, 1'b0, 1'b0, 8'd3,  1'b1, 12'h000},
        '{4'd4,  2'd0, 1'b0, 1'b0, 8'd5,  1'b0, 12'h000},
        '{4'd7,  2'd0, 1'b0, 1'b0, 8'd4,  1'b0, 12'h000},
        '{4'd9,  2'd0, 1'b0, 1'b0, 8'd3,  1'b1, 12'hAAA},
        '{4'd10, 2'd0, 1'b0, 1'b0, 8'd3,  1'b1, 12'h03F},
        '{4'd11, 2'd0, 1'b0, 1'b0, 8'd14, 1'b0, 12'h000},
        '{4'd12, 2'd0, 1'b0, 1'b0, 8'd18, 1'b0, 12'h000},
        '{4'd5,  2'd0, 1'b0, 1'b0, 8'd6,  1'b0, 12'h000},
        '{4'd5,  2'd0, 1'b1, 1'b0, 8'd3,  1'b0, 12'h000},
        '{4'd5,  2'd0, 1'b0, 1'b1, 8'd4,  1'b0, 12'h000},
        '{4'd6,  2'd0, 1'b0, 1'b0, 8'd6,  1'b0, 12'h000},
        '{4'd6,  2'd0, 1'b0, 1'b1, 8'd3,  1'b0, 12'h000},
        '{4'd6,  2'd0, 1'b1, 1'b0, 8'd4,  1'b0, 12'h000},
        '{4'd8,  2'd0, 1'b0, 1'b0, 8'd3,  1'b0, 12'h000},
        '{4'd8,  2'd1, 1'b0, 1'b0, 8'd4,  1'b0, 12'h000},
        '{4'd8,  2'd2, 1'b0, 1'b0, 8'd4,  1'b0, 12'h000},
        '{4'd8,  2'd3, 1'b0, 1'b0, 8'd5,  1'b0, 12'h000},
        '{4'd13, 2'd0, 1'b0, 1'b0, 8'd3,  1'b0, 12'h000},
        '{4'd14, 2'd1, 1'b0, 1'b0, 8'd2,  1'b0, 12'h000},
        '{4'd15, 2'd0, 1'b0, 1'b0, 8'd2,  1'b0, 12'h000},
        '{4'd0,  2'd0, 1'b0, 1'b0, 8'd2,  1'b0, 12'h000}
    };

    function automatic string req_of(input logic [3:0] m, input logic [1:0] s);
        case (m)
            4'd1, 4'd2, 4'd3: return "R3";
            4'd4:             return "R4";
            4'd7, 4'd9:       return "R5";
            4'd10, 4'd11:     return "R6";
            4'd12:            return "R7";
            4'd5:             return "R9";
            4'd6:             return "R8";
            4'd8:             return (s >= 2'd2) ? "R12" : "R11";
            default:          return "R2";
        endcase
    endfunction

    // Twelve steps of x^23+x^18+1, oldest feedback bit ends in the MSB.
    function automatic logic [34:0] run_long(input logic [22:0] s);
        logic [11:0] w = '0;
        logic        b;
        for (int k = 0; k < 12; k++) begin
            b = s[22] ^ s[17];
            s = {s[21:0], b};
            w = {w[10:0], b};
        end
        return {w, s};
    endfunction

    // Twelve steps of x^9+x^5+1.
    function automatic logic [20:0] run_short(input logic [8:0] s);
        logic [11:0] w = '0;
        logic        b;
        for (int k = 0; k < 12; k++) begin
            b = s[8] ^ s[4];
            s = {s[7:0], b};
            w = {w[10:0], b};
        end
        return {w, s};
    endfunction

    task automatic model_reset();
        m_cfg  = '0;
        m_idx  = '0;
        m_walk = '0;
        m_once = '0;
        m_pl   = '1;
        m_ps   = '1;
    endtask

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp_w);
        checks++;
        if (act !== exp_w) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp_w);
        end
    endtask

    // One sample: drive at a falling edge, compute the expected word, check at the next falling edge.
    task automatic step(input logic [3:0] m, input logic [1:0] s, input logic hl, input logic hs,
                        input logic [11:0] lv, input string tag, output logic [11:0] got);
        logic [11:0] exp_w;
        logic [34:0] rl;
        logic [20:0] rs;
        logic [3:0]  ix;
        logic [3:0]  wk;
        logic [1:0]  on;
        pat_sel = m; seq_sel = s; pn_long_hold = hl; pn_short_hold = hs; live_word = lv;
        if ({m, s} != m_cfg) begin ix = 0; wk = 0; on = 0; end
        else begin ix = m_idx; wk = m_walk; on = m_once; end
        rl = run_long(hl ? 23'h7FFFFF : m_pl);
        rs = run_short(hs ? 9'h1FF : m_ps);
        case (m)
            4'd1:  exp_w = 12'h800;
            4'd2:  exp_w = 12'hFFF;
            4'd3:  exp_w = 12'h000;
            4'd4:  exp_w = ix[0] ? 12'h555 : 12'hAAA;
            4'd5:  exp_w = rl[34:23];
            4'd6:  exp_w = rs[20:9];
            4'd7:  exp_w = ix[0] ? 12'h000 : 12'hFFF;
            4'd8: begin
                case (s)
                    2'd0: exp_w = user_word_a;
                    2'd1: exp_w = ix[0] ? user_word_b : user_word_a;
                    2'd2: exp_w = (on == 0) ? user_word_a : lv;
                    default: exp_w = (on == 0) ? user_word_a : (on == 1) ? user_word_b : lv;
                endcase
            end
            4'd9:  exp_w = 12'hAAA;
            4'd10: exp_w = 12'h03F;
            4'd11: exp_w = 12'h001 << wk;
            4'd12: exp_w = {ix[3:0], ix[3:0], ix[3:0]};
            default: exp_w = lv;
        endcase
        m_cfg  = {m, s};
        m_idx  = ix + 1;
        m_walk = (wk == 11) ? 4'd0 : wk + 1;
        m_once = (on == 2) ? 2'd2 : on + 1;
        m_pl   = hl ? 23'h7FFFFF : rl[22:0];
        m_ps   = hs ? 9'h1FF : rs[8:0];
        @(posedge clk);
        @(negedge clk);
        got = word_out;
        check(tag, word_out, exp_w);
        if (word_valid !== 1'b1) begin
            checks++;
            errors++;
            $display("FAIL R1: valid actual=%0b expected=1", word_valid);
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        pat_sel = 4'd6; seq_sel = 2'd0; pn_long_hold = 1'b0; pn_short_hold = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        check("R1 reset word", word_out, 12'h000);
        check("R1 reset valid", {11'd0, word_valid}, 12'h000);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        logic [11:0] got;
        logic [11:0] lv;
        logic [11:0] seed_short;
        logic [20:0] rs0;
        rst = 1'b1;
        live_word = '0; pat_sel = '0; seq_sel = '0;
        pn_long_hold = 1'b0; pn_short_hold = 1'b0;
        user_word_a = 12'h5A3; user_word_b = 12'hC3C;
        @(negedge clk);
        do_reset(3);

        // Table walk
        lv = 12'h100;
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < int'(VECS[v].cyc); c++) begin
                lv = lv + 12'h25;
                step(VECS[v].mode, VECS[v].seq, VECS[v].hl, VECS[v].hs, lv,
                     req_of(VECS[v].mode, VECS[v].seq), got);
                if (VECS[v].fixed) check(req_of(VECS[v].mode, VECS[v].seq), got, VECS[v].expect_w);
            end
        end

        // R13: walking position restarts after leaving and returning
        for (int c = 0; c < 5; c++) step(4'd11, 2'd0, 1'b0, 1'b0, 12'h0, "R6", got);
        step(4'd4, 2'd0, 1'b0, 1'b0, 12'h0, "R13", got);
        step(4'd11, 2'd0, 1'b0, 1'b0, 12'h0, "R13", got);
        check("R13 walk restart", got, 12'h001);

        // R13 vs R12 in the same cycle: sequencing changes where user_word_b was due
        step(4'd8, 2'd3, 1'b0, 1'b0, 12'h7E1, "R12", got);
        check("R12 pair first", got, 12'h5A3);
        step(4'd8, 2'd2, 1'b0, 1'b0, 12'h7E2, "R13", got);
        check("R13 seq restart", got, 12'h5A3);
        step(4'd8, 2'd2, 1'b0, 1'b0, 12'h7E3, "R12", got);
        check("R12 once then live", got, 12'h7E3);

        // R10: hold released on a sample where the stream is read
        rs0 = run_short(9'h1FF);
        seed_short = rs0[20:9];
        step(4'd6, 2'd0, 1'b0, 1'b1, 12'h0, "R10", got);
        check("R10 seed word", got, seed_short);
        step(4'd6, 2'd0, 1'b0, 1'b0, 12'h0, "R10", got);
        check("R10 first after seed", got, seed_short);
        step(4'd6, 2'd0, 1'b0, 1'b0, 12'h0, "R8", got);

        // R1: reset in mid-run, then the first sample matches the seed word
        do_reset(2);
        step(4'd6, 2'd0, 1'b0, 1'b0, 12'h0, "R1", got);
        check("R1 restart stream", got, seed_short);
        step(4'd0, 2'd0, 1'b0, 1'b0, 12'hABC, "R2", got);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule